// File: doc/BRIEF.md
# Texture Request Assembler

This block sits between a shader's coordinate register writes and a texture sampling back end. The shader writes coordinate values to four registers: S, T, R and bias. Every accepted write takes the next configuration word from a uniform FIFO and stores it next to the coordinate in a shared receive queue. A write to S ends the current request. The head request is then offered downstream as one record. The record holds every coordinate and every configuration word that belongs to the request, and it also carries the first configuration word decoded into its fields.

A request has one to four writes, and S is always the last of them. The queue counts register writes, not requests. With the default depth of eight it can therefore hold eight one-write requests, four two-write requests or two four-write requests. A coordinate write is stalled in two cases: when the queue has no free entry, and when the uniform FIFO has no word to supply.

Top module: `tex_req_assembler`

## Requirements
- R1: After reset the queue is empty: `occupancy` is 0, `q_full` is 0 and `req_valid` is 0.
- R2: Each accepted write pops exactly one uniform word (`uni_pop` high in that cycle). The k-th write of a request, counted from 0, places its word in `req_cfg[k*32 +: 32]`.
- R3: Register codes are 0 = S, 1 = T, 2 = R and 3 = B. A request is offered only after its S write. The record gives the number of writes in `req_words`, sets bit c of `req_mask` for each code c written, and routes each value to `req_s`, `req_t`, `req_r` or `req_b`.
- R4: The first configuration word of a request, w, is decoded as follows:
  - `req_base` = {w[31:12], 12'h000}, a byte address aligned to 4 KiB
  - `req_swizzle` = w[11:10]
  - `req_fmt_lo` = w[7:4]
  - `req_mip_max` = w[3:0], which is the number of mip levels minus one
- R5: `occupancy` counts queued register writes. `q_full` is high at DEPTH. A write while full raises `wr_stall`, pops no uniform word and leaves the queue unchanged.
- R6: A write while `uni_valid` is low raises `wr_stall` and adds no entry.
- R7: While `req_valid` is high and `req_ready` is low, the record stays valid and unchanged. On a handshake, all entries of that request are freed.
- R8: A write can be accepted in the same cycle as a dispatch. The occupancy then becomes the old value + 1 - the dispatched request's write count.
- R9: An open request holds at most three non-S writes. A fourth non-S write stalls until S is written. If a register is written twice in one request, the later value appears in the record.
- R10: Requests are dispatched in the order of their S writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Coordinate write request |
| wr_sel | input | 2 | Register code: 0 = S, 1 = T, 2 = R, 3 = B |
| wr_data | input | DW | Coordinate value |
| wr_stall | output | 1 | Write is refused this cycle |
| uni_valid | input | 1 | Uniform FIFO has a word |
| uni_data | input | 32 | Uniform FIFO head word |
| uni_pop | output | 1 | Consume the uniform head word |
| req_valid | output | 1 | Complete request at the head of the queue |
| req_ready | input | 1 | Back end accepts the request |
| req_words | output | 3 | Number of writes in the request |
| req_mask | output | 4 | Registers present, one bit per register code |
| req_s | output | DW | S coordinate |
| req_t | output | DW | T coordinate |
| req_r | output | DW | R coordinate |
| req_b | output | DW | Bias |
| req_cfg | output | 128 | Configuration words in write order |
| req_base | output | 32 | Decoded LOD0 byte address |
| req_swizzle | output | 2 | Decoded cache swizzle mode |
| req_fmt_lo | output | 4 | Decoded low bits of the pixel format |
| req_mip_max | output | 4 | Decoded mip level count minus one |
| occupancy | output | $clog2(DEPTH)+1 | Queued register writes |
| q_full | output | 1 | Queue has no free entry |

## Verification
A coordinate write and a request dispatch can happen in the same clock cycle. Both then change the occupancy count and the read pointer together. The bench provokes this with a two-write request waiting at the head: it raises `req_ready` in the same cycle that it drives a new T write. At the next falling edge it expects an occupancy of 1 and no valid request. It then completes the new request and checks that the record contains only the new request's values. The bench also fills the queue and checks that a refused write leaves the queue's contents unchanged.

// File: rtl/tex_req_assembler.sv
module tex_req_assembler #(
  parameter int DEPTH = 8,
  parameter int DW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [1:0]               wr_sel,
  input  logic [DW-1:0]            wr_data,
  output logic                     wr_stall,
  input  logic                     uni_valid,
  input  logic [31:0]              uni_data,
  output logic                     uni_pop,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [2:0]               req_words,
  output logic [3:0]               req_mask,
  output logic [DW-1:0]            req_s,
  output logic [DW-1:0]            req_t,
  output logic [DW-1:0]            req_r,
  output logic [DW-1:0]            req_b,
  output logic [127:0]             req_cfg,
  output logic [31:0]              req_base,
  output logic [1:0]               req_swizzle,
  output logic [3:0]               req_fmt_lo,
  output logic [3:0]               req_mip_max,
  output logic [$clog2(DEPTH):0]   occupancy,
  output logic                     q_full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_N = (AW+1)'(DEPTH);

  logic [1:0]    e_sel [DEPTH];
  logic [DW-1:0] e_dat [DEPTH];
  logic [31:0]   e_cfg [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   occ, nreq;
  logic [1:0]    open_n;

  logic is_s, acc, pop;
  assign is_s     = (wr_sel == 2'd0);
  assign q_full   = (occ == FULL_N);
  assign acc      = wr_valid && uni_valid && !q_full && (is_s || open_n != 2'd3);
  assign wr_stall = wr_valid && !acc;
  assign uni_pop  = acc;

  assign req_valid = (nreq != '0);
  assign pop       = req_valid && req_ready;
  assign occupancy = occ;

  always_comb begin : head_scan
    logic [AW-1:0] ix;
    logic found;
    ix = '0;
    found = 1'b0;
    req_words = '0;
    req_mask = '0;
    req_s = '0;
    req_t = '0;
    req_r = '0;
    req_b = '0;
    req_cfg = '0;
    for (int k = 0; k < 4; k++) begin
      ix = rp + AW'(k);
      if (!found && (AW+1)'(k) < occ) begin
        req_cfg[k*32 +: 32] = e_cfg[ix];
        req_words = 3'(k + 1);
        req_mask[e_sel[ix]] = 1'b1;
        case (e_sel[ix])
          2'd0: req_s = e_dat[ix];
          2'd1: req_t = e_dat[ix];
          2'd2: req_r = e_dat[ix];
          2'd3: req_b = e_dat[ix];
        endcase
        if (e_sel[ix] == 2'd0) found = 1'b1;
      end
    end
  end

  assign req_base    = {req_cfg[31:12], 12'h000};
  assign req_swizzle = req_cfg[11:10];
  assign req_fmt_lo  = req_cfg[7:4];
  assign req_mip_max = req_cfg[3:0];

  always_ff @(posedge clk) begin
    if (acc) begin
      e_sel[wp] <= wr_sel;
      e_dat[wp] <= wr_data;
      e_cfg[wp] <= uni_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      occ <= '0;
      nreq <= '0;
      open_n <= '0;
    end else begin
      if (acc) begin
        wp <= wp + 1'b1;
        open_n <= is_s ? 2'd0 : open_n + 2'd1;
      end
      if (pop) rp <= rp + AW'(req_words);
      occ <= occ + (AW+1)'(acc) - (pop ? (AW+1)'(req_words) : '0);
      nreq <= nreq + (AW+1)'(acc && is_s) - (AW+1)'(pop);
    end
  end

  // R5
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= FULL_N);
  // R5
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full && wr_valid |-> wr_stall && !uni_pop);
  // R6
  no_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !uni_valid |-> wr_stall && !uni_pop);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_s) && $stable(req_words) && $stable(req_cfg));
  // R2
  pop_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uni_pop |-> wr_valid && uni_valid && !wr_stall);
  // R3
  closed_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_mask[0] && req_words != 3'd0 && req_words <= 3'd4);
  // R8
  occ_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !uni_pop && !(req_valid && req_ready) |=> $stable(occupancy));
endmodule

// File: tb/test_tex_req_assembler.sv
`timescale 1ns/1ps
module test_tex_req_assembler;
  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, uni_valid = 0, req_ready = 0;
  logic [1:0] wr_sel = 0;
  logic [31:0] wr_data = 0, uni_data = 0;
  logic wr_stall, uni_pop, req_valid, q_full;
  logic [2:0] req_words;
  logic [3:0] req_mask, req_fmt_lo, req_mip_max;
  logic [31:0] req_s, req_t, req_r, req_b, req_base;
  logic [127:0] req_cfg;
  logic [1:0] req_swizzle;
  logic [3:0] occupancy;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tex_req_assembler i_tex_req_assembler (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
    .wr_stall(wr_stall), .uni_valid(uni_valid), .uni_data(uni_data), .uni_pop(uni_pop),
    .req_valid(req_valid), .req_ready(req_ready), .req_words(req_words), .req_mask(req_mask),
    .req_s(req_s), .req_t(req_t), .req_r(req_r), .req_b(req_b), .req_cfg(req_cfg),
    .req_base(req_base), .req_swizzle(req_swizzle), .req_fmt_lo(req_fmt_lo),
    .req_mip_max(req_mip_max), .occupancy(occupancy), .q_full(q_full));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d, input logic [31:0] c,
                    input bit uv, input bit exp_acc, input string tag);
    @(negedge clk);
    wr_valid = 1; wr_sel = sel; wr_data = d; uni_valid = uv; uni_data = c;
    #1;
    chk(wr_stall == !exp_acc, {tag, " stall"}, 64'(wr_stall), 64'(!exp_acc));
    chk(uni_pop == exp_acc, {tag, " pop"}, 64'(uni_pop), 64'(exp_acc));
    @(posedge clk); #1;
    wr_valid = 0; uni_valid = 0;
  endtask

  task automatic chk_occ(input int exp, input string tag);
    @(negedge clk);
    chk(occupancy == 4'(exp), {tag, " occupancy"}, 64'(occupancy), 64'(exp));
  endtask

  task automatic take(input logic [2:0] words, input logic [3:0] mask, input logic [31:0] s,
                      input logic [31:0] t, input logic [31:0] cfg0, input string tag);
    @(negedge clk);
    chk(req_valid == 1, {tag, " valid"}, 64'(req_valid), 1);
    chk(req_words == words, {tag, " words"}, 64'(req_words), 64'(words));
    chk(req_mask == mask, {tag, " mask"}, 64'(req_mask), 64'(mask));
    chk(req_s == s, {tag, " s"}, 64'(req_s), 64'(s));
    if (mask[1]) chk(req_t == t, {tag, " t"}, 64'(req_t), 64'(t));
    chk(req_cfg[31:0] == cfg0, {tag, " cfg0"}, 64'(req_cfg[31:0]), 64'(cfg0));
    req_ready = 1;
    @(posedge clk); #1;
    req_ready = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(occupancy == 0, "R1 occupancy", 64'(occupancy), 0);
    chk(q_full == 0, "R1 full", 64'(q_full), 0);
    chk(req_valid == 0, "R1 valid", 64'(req_valid), 0);
  endtask

  task automatic t_one_write;
    wr(0, 32'h1111, 32'hABCDE5A3, 1, 1, "R2 1d");
    @(negedge clk);
    chk(req_base == 32'hABCDE000, "R4 base", 64'(req_base), 64'hABCDE000);
    chk(req_swizzle == 2'b01, "R4 swizzle", 64'(req_swizzle), 1);
    chk(req_fmt_lo == 4'hA, "R4 fmt", 64'(req_fmt_lo), 64'hA);
    chk(req_mip_max == 4'h3, "R4 mip", 64'(req_mip_max), 3);
    take(1, 4'b0001, 32'h1111, 0, 32'hABCDE5A3, "R3 1d");
    chk_occ(0, "R7 freed");
  endtask

  task automatic t_two_write;
    wr(1, 32'h2222, 32'h0000C0F1, 1, 1, "R2 2d T");
    @(negedge clk);
    chk(req_valid == 0, "R3 open not offered", 64'(req_valid), 0);
    wr(0, 32'h3333, 32'h55, 1, 1, "R2 2d S");
    @(negedge clk);
    chk(req_cfg[63:32] == 32'h55, "R2 cfg order", 64'(req_cfg[63:32]), 64'h55);
    chk(req_mip_max == 4'h1, "R4 decode first word", 64'(req_mip_max), 1);
    take(2, 4'b0011, 32'h3333, 32'h2222, 32'h0000C0F1, "R3 2d");
  endtask

  task automatic t_four_write;
    wr(1, 32'h10, 32'hC0, 1, 1, "R3 4w T");
    wr(2, 32'h20, 32'hC1, 1, 1, "R3 4w R");
    wr(3, 32'h30, 32'hC2, 1, 1, "R3 4w B");
    wr(3, 32'h31, 32'hC9, 1, 0, "R9 fourth non-S");
    wr(0, 32'h40, 32'hC3, 1, 1, "R3 4w S");
    @(negedge clk);
    chk(req_r == 32'h20, "R3 r", 64'(req_r), 64'h20);
    chk(req_b == 32'h30, "R3 b", 64'(req_b), 64'h30);
    chk(req_cfg[127:96] == 32'hC3, "R2 cfg3", 64'(req_cfg[127:96]), 64'hC3);
    take(4, 4'b1111, 32'h40, 32'h10, 32'hC0, "R3 4w");
  endtask

  task automatic t_duplicate;
    wr(1, 32'hA, 32'h1, 1, 1, "R9 dup T1");
    wr(1, 32'hB, 32'h2, 1, 1, "R9 dup T2");
    wr(0, 32'hC, 32'h3, 1, 1, "R9 dup S");
    take(3, 4'b0011, 32'hC, 32'hB, 32'h1, "R9 dup");
  endtask

  task automatic t_no_uniform;
    wr(0, 32'h99, 32'h0, 0, 0, "R6 empty uniform");
    chk_occ(0, "R6");
    chk(req_valid == 0, "R6 no request", 64'(req_valid), 0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 8; i++) wr(0, 32'(i), 32'(i + 100), 1, 1, "R5 fill");
    chk_occ(8, "R5 filled");
    chk(q_full == 1, "R5 full flag", 64'(q_full), 1);
    wr(0, 32'hEE, 32'hEE, 1, 0, "R5 refused");
    chk_occ(8, "R5 unchanged");
    take(1, 4'b0001, 0, 0, 100, "R10 order 0");
    wr(0, 32'd8, 32'd108, 1, 1, "R5 after free");
    for (int i = 1; i <= 8; i++) take(1, 4'b0001, 32'(i), 0, 32'(i + 100), "R10 order");
    chk_occ(0, "R5 drained");
  endtask

  task automatic t_hold;
    wr(1, 32'h71, 32'h70, 1, 1, "R7 T");
    wr(0, 32'h72, 32'h73, 1, 1, "R7 S");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(req_valid && req_s == 32'h72, "R7 held", 64'(req_s), 64'h72);
    end
    take(2, 4'b0011, 32'h72, 32'h71, 32'h70, "R7 release");
  endtask

  task automatic t_same_cycle;
    wr(1, 32'h11, 32'hF0, 1, 1, "R8 T");
    wr(0, 32'h22, 32'hF1, 1, 1, "R8 S");
    @(negedge clk);
    req_ready = 1; wr_valid = 1; wr_sel = 1; wr_data = 32'h33; uni_valid = 1; uni_data = 32'h44;
    #1;
    chk(wr_stall == 0, "R8 accept with dispatch", 64'(wr_stall), 0);
    @(posedge clk); #1;
    req_ready = 0; wr_valid = 0; uni_valid = 0;
    @(negedge clk);
    chk(occupancy == 1, "R8 occupancy", 64'(occupancy), 1);
    chk(req_valid == 0, "R8 no stale request", 64'(req_valid), 0);
    wr(0, 32'h55, 32'h66, 1, 1, "R8 S2");
    take(2, 4'b0011, 32'h55, 32'h33, 32'h44, "R8 record");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_one_write;
    t_two_write;
    t_four_write;
    t_duplicate;
    t_no_uniform;
    t_full;
    t_hold;
    t_same_cycle;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule